// File: doc/BRIEF.md
# Descriptor Checksum Unit

This block produces and verifies the one-byte integrity code carried by a 16-byte transfer descriptor. A descriptor reaches it over one of two independent paths. The first is a byte stream that delivers one byte per accepted cycle. The second is a full 128-bit word presented in a single cycle. In generate mode the block returns the code byte that software or a descriptor writer places in the descriptor. In check mode it recomputes the code and raises an error strobe when the stored code differs. A queue engine reports that strobe as a descriptor integrity fault.

The code is computed by wrap-around 8-bit addition of all descriptor bytes, with two adjustments. The code byte itself counts as zero. The ownership bit of the flag byte is also counted as clear. One is then added, because the descriptor is handed over with ownership set, and the result is 0xFF minus that total. Because of this rule a descriptor gives the same code whether its ownership bit is set or clear, so the code can be written before ownership is handed over.

Top module: `dcs_desc_checksum`

## Requirements
- R1: The code is 0xFF minus (1 plus the modulo-256 sum of the 16 descriptor bytes), taken modulo 256. Byte k occupies word bits [8k+7:8k] and is the k-th byte accepted on the stream.
- R2: Byte 1, the code byte, is treated as zero while summing, so its value never changes the computed code.
- R3: Bit 0 of byte 0, the ownership bit, is treated as clear while summing, so setting or clearing it never changes the computed code.
- R4: In generate mode (mode input low) the error strobe stays low.
- R5: In check mode (mode input high) the error strobe is high together with the done strobe exactly when byte 1 differs from the computed code.
- R6: A word presented with `par_valid` yields `par_done`, `par_code` and `par_err` on the next cycle. `par_done` is low in every cycle that does not follow a `par_valid` cycle.
- R7: `str_start` opens a new descriptor and captures the mode. A byte presented with `str_valid` in the same cycle as `str_start` is byte 0. `str_done` is a one-cycle strobe, in the cycle after the sixteenth byte is accepted, that comes with `str_code` and `str_err`.
- R8: Stream bytes that arrive before any `str_start`, or after the sixteenth byte and before the next `str_start`, are ignored. They raise no strobe and change no output.
- R9: `str_start` in the middle of a descriptor discards the partial sum, and counting restarts at byte 0.
- R10: After reset both done strobes and both error strobes are low, and both code outputs are zero.
- R11: Cycles with `str_valid` low do not advance the stream; gaps between bytes leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| str_start | input | 1 | Opens a new streamed descriptor |
| str_check | input | 1 | Mode for the streamed descriptor, captured with `str_start` (1 = check) |
| str_valid | input | 1 | A stream byte is presented |
| str_byte | input | 8 | Stream byte |
| str_done | output | 1 | Stream result strobe |
| str_code | output | 8 | Stream computed code, held until the next result |
| str_err | output | 1 | Stream mismatch strobe |
| par_valid | input | 1 | A full descriptor word is presented |
| par_check | input | 1 | Mode for the word (1 = check) |
| par_word | input | 128 | Descriptor word, byte k at bits [8k+7:8k] |
| par_done | output | 1 | Word result strobe |
| par_code | output | 8 | Word computed code, held until the next result |
| par_err | output | 1 | Word mismatch strobe |

## Verification
The bench goes after the two masking rules first. A design that summed the code byte would give a different code when only byte 1 changes. A design that kept the ownership bit would give a code off by one when byte 0 is odd. On the stream side it sends bytes before any start, extra bytes after the sixteenth, a restart in the middle of a descriptor and long gaps. A counter that does not saturate would emit a second strobe, and one that keeps a stale partial sum on restart would return a wrong code. Check-mode descriptors carry both correct and corrupted code bytes, so an inverted or always-low error strobe shows up, and a mode latched at the wrong time shows up when the mode input changes during a streamed descriptor.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  localparam int BYTE_W = 8;

  // Contribution of one descriptor byte to the running sum.
  function automatic logic [BYTE_W-1:0] fold_byte(
    input logic [BYTE_W-1:0] b,
    input logic              is_code,
    input logic              is_flag,
    input int                own_bit
  );
    logic [BYTE_W-1:0] r;
    r = b;
    if (is_flag) r = r & ~(BYTE_W'(1) << own_bit);
    if (is_code) r = '0;
    return r;
  endfunction

endpackage

// File: rtl/dcs_verdict.sv
module dcs_verdict
  import dcs_pkg::*;
(
  input  logic [BYTE_W-1:0] sum_in,
  input  logic [BYTE_W-1:0] stored_code,
  input  logic              check_mode,
  output logic [BYTE_W-1:0] code_out,
  output logic              mismatch
);

  logic [BYTE_W-1:0] with_owner;

  always_comb begin
    with_owner = sum_in + BYTE_W'(1);
    code_out   = {BYTE_W{1'b1}} - with_owner;
    mismatch   = check_mode && (code_out != stored_code);
  end

endmodule

// File: rtl/dcs_stream_acc.sv
module dcs_stream_acc
  import dcs_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  parameter int CODE_IDX  = 1,
  parameter int FLAG_IDX  = 0,
  parameter int OWN_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              check_in,
  input  logic              valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              done,
  output logic [BYTE_W-1:0] code,
  output logic              err
);

  localparam int CNT_W = $clog2(NUM_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(NUM_BYTES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NUM_BYTES - 1);
  localparam logic [CNT_W-1:0] CODE_POS = CNT_W'(CODE_IDX);
  localparam logic [CNT_W-1:0] FLAG_POS = CNT_W'(FLAG_IDX);

  logic [CNT_W-1:0]  cnt, base_cnt;
  logic [BYTE_W-1:0] acc, base_acc, next_acc;
  logic [BYTE_W-1:0] stored, base_stored, next_stored;
  logic              mode_q, mode_now;
  logic              take, last;
  logic [BYTE_W-1:0] v_code;
  logic              v_err;

  always_comb begin
    base_cnt    = start ? '0 : cnt;
    base_acc    = start ? '0 : acc;
    base_stored = start ? '0 : stored;
    mode_now    = start ? check_in : mode_q;
    take        = valid && (base_cnt < FULL);
    last        = take && (base_cnt == LAST_POS);
    next_acc    = base_acc + fold_byte(byte_in, base_cnt == CODE_POS,
                                       base_cnt == FLAG_POS, OWN_BIT);
    next_stored = (take && base_cnt == CODE_POS) ? byte_in : base_stored;
  end

  dcs_verdict verdict_i (
    .sum_in      (next_acc),
    .stored_code (next_stored),
    .check_mode  (mode_now),
    .code_out    (v_code),
    .mismatch    (v_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= FULL;
      acc    <= '0;
      stored <= '0;
      mode_q <= 1'b0;
      done   <= 1'b0;
      code   <= '0;
      err    <= 1'b0;
    end else begin
      done <= last;
      err  <= last && v_err;
      if (last) code <= v_code;
      if (start) mode_q <= check_in;
      if (start || take) begin
        cnt    <= take ? base_cnt + CNT_W'(1) : base_cnt;
        acc    <= take ? next_acc : base_acc;
        stored <= next_stored;
      end
    end
  end

  // R7: the result strobe never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: a mismatch is reported only together with a result
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R8: with the descriptor complete and no restart, the sum is frozen
  a_r8_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL && !start) |=> $stable(acc) && !done);
  // R11: an idle cycle does not move the byte position
  a_r11_gap_hold: assert property (@(posedge clk) disable iff (rst)
    (!valid && !start) |=> $stable(cnt));

endmodule

// File: rtl/dcs_parallel_sum.sv
module dcs_parallel_sum
  import dcs_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  parameter int CODE_IDX  = 1,
  parameter int FLAG_IDX  = 0,
  parameter int OWN_BIT   = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid,
  input  logic                        check_in,
  input  logic [NUM_BYTES*BYTE_W-1:0] word,
  output logic                        done,
  output logic [BYTE_W-1:0]           code,
  output logic                        err
);

  logic [BYTE_W-1:0] folded [NUM_BYTES];
  logic [BYTE_W-1:0] total;
  logic [BYTE_W-1:0] v_code;
  logic              v_err;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    assign folded[i] = fold_byte(word[i*BYTE_W +: BYTE_W],
                                 i == CODE_IDX, i == FLAG_IDX, OWN_BIT);
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_BYTES; i++) total = total + folded[i];
  end

  dcs_verdict verdict_i (
    .sum_in      (total),
    .stored_code (word[CODE_IDX*BYTE_W +: BYTE_W]),
    .check_mode  (check_in),
    .code_out    (v_code),
    .mismatch    (v_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      code <= '0;
      err  <= 1'b0;
    end else begin
      done <= valid;
      err  <= valid && v_err;
      if (valid) code <= v_code;
    end
  end

  // R6: one result per presented word, one cycle later
  a_r6_done_follows: assert property (@(posedge clk) disable iff (rst)
    valid |=> done);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !done);
  // R4: generate mode never flags a mismatch
  a_r4_gen_quiet: assert property (@(posedge clk) disable iff (rst)
    (valid && !check_in) |=> !err);

endmodule

// File: rtl/dcs_desc_checksum.sv
module dcs_desc_checksum
  import dcs_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  parameter int CODE_IDX  = 1,
  parameter int FLAG_IDX  = 0,
  parameter int OWN_BIT   = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        str_start,
  input  logic                        str_check,
  input  logic                        str_valid,
  input  logic [BYTE_W-1:0]           str_byte,
  output logic                        str_done,
  output logic [BYTE_W-1:0]           str_code,
  output logic                        str_err,
  input  logic                        par_valid,
  input  logic                        par_check,
  input  logic [NUM_BYTES*BYTE_W-1:0] par_word,
  output logic                        par_done,
  output logic [BYTE_W-1:0]           par_code,
  output logic                        par_err
);

  dcs_stream_acc #(
    .NUM_BYTES (NUM_BYTES),
    .CODE_IDX  (CODE_IDX),
    .FLAG_IDX  (FLAG_IDX),
    .OWN_BIT   (OWN_BIT)
  ) stream_i (
    .clk      (clk),
    .rst      (rst),
    .start    (str_start),
    .check_in (str_check),
    .valid    (str_valid),
    .byte_in  (str_byte),
    .done     (str_done),
    .code     (str_code),
    .err      (str_err)
  );

  dcs_parallel_sum #(
    .NUM_BYTES (NUM_BYTES),
    .CODE_IDX  (CODE_IDX),
    .FLAG_IDX  (FLAG_IDX),
    .OWN_BIT   (OWN_BIT)
  ) par_i (
    .clk      (clk),
    .rst      (rst),
    .valid    (par_valid),
    .check_in (par_check),
    .word     (par_word),
    .done     (par_done),
    .code     (par_code),
    .err      (par_err)
  );

  // R10: reset leaves both paths quiet
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !str_done && !par_done && !str_err && !par_err);

endmodule

// File: tb/dcs_desc_checksum_tb_top.sv
module dcs_desc_checksum_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk; // 250 MHz

  logic         str_start = 0, str_check = 0, str_valid = 0;
  logic [7:0]   str_byte = 0;
  logic         par_valid = 0, par_check = 0;
  logic [127:0] par_word = '0;
  logic         str_done, str_err, par_done, par_err;
  logic [7:0]   str_code, par_code;

  dcs_desc_checksum dut_i (
    .clk(clk), .rst(rst),
    .str_start(str_start), .str_check(str_check), .str_valid(str_valid),
    .str_byte(str_byte), .str_done(str_done), .str_code(str_code),
    .str_err(str_err), .par_valid(par_valid), .par_check(par_check),
    .par_word(par_word), .par_done(par_done), .par_code(par_code),
    .par_err(par_err)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R10";

  // reference model state
  byte unsigned q[$];
  bit           s_active = 0;
  bit           s_mode = 0;
  bit           e_sdone = 0, e_serr = 0, e_pdone = 0, e_perr = 0;
  logic [7:0]   e_scode = 0, e_pcode = 0;

  function automatic logic [7:0] ref_code(input logic [127:0] d);
    int s = 0;
    for (int i = 0; i < 16; i++) begin
      int b = d[i*8 +: 8];
      if (i == 1) b = 0;
      if (i == 0) b = b & 8'hFE;
      s = s + b;
    end
    return 8'(255 - ((s + 1) % 256));
  endfunction

  task automatic check1(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", t, act, exp, $time);
    end
  endtask

  task automatic check8(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", t, act, exp, $time);
    end
  endtask

  task automatic model();
    logic [127:0] d;
    e_sdone = 0; e_serr = 0; e_pdone = 0; e_perr = 0;
    if (rst) begin
      q.delete(); s_active = 0; e_scode = 0; e_pcode = 0;
      return;
    end
    if (str_start) begin q.delete(); s_active = 1; s_mode = str_check; end
    if (str_valid && s_active && q.size() < 16) begin
      q.push_back(str_byte);
      if (q.size() == 16) begin
        for (int i = 0; i < 16; i++) d[i*8 +: 8] = q[i];
        e_sdone = 1;
        e_scode = ref_code(d);
        e_serr  = s_mode && (q[1] != e_scode);
        s_active = 0;
      end
    end
    if (par_valid) begin
      e_pdone = 1;
      e_pcode = ref_code(par_word);
      e_perr  = par_check && (par_word[15:8] != e_pcode);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model();
    @(negedge clk);
    check1({tag, "/R7 str_done"}, str_done, e_sdone);
    check8({tag, "/R1 str_code"}, str_code, e_scode);
    check1({tag, "/R5 str_err"},  str_err,  e_serr);
    check1({tag, "/R6 par_done"}, par_done, e_pdone);
    check8({tag, "/R1 par_code"}, par_code, e_pcode);
    check1({tag, "/R5 par_err"},  par_err,  e_perr);
  endtask

  task automatic send_par(logic [127:0] d, logic chk);
    par_valid = 1; par_word = d; par_check = chk;
    cycle();
    par_valid = 0;
  endtask

  // stream one descriptor; gap>0 inserts idle cycles between bytes
  task automatic send_str(logic [127:0] d, logic chk, int gap);
    for (int i = 0; i < 16; i++) begin
      str_start = (i == 0); str_check = chk;
      str_valid = 1; str_byte = d[i*8 +: 8];
      cycle();
      str_start = 0; str_valid = 0; str_check = ~chk; // mode must be latched
      for (int g = 0; g < gap; g++) cycle();
    end
  endtask

  function automatic logic [127:0] rnd_desc();
    logic [127:0] d;
    for (int i = 0; i < 4; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] d;
    @(negedge clk);
    repeat (3) cycle();
    rst = 0;
    tag = "R10";
    check1("R10 str_done after reset", str_done, 1'b0);
    check1("R10 par_done after reset", par_done, 1'b0);
    check8("R10 str_code after reset", str_code, 8'h00);
    check8("R10 par_code after reset", par_code, 8'h00);
    cycle();

    // R8: bytes before any start are ignored
    tag = "R8";
    for (int i = 0; i < 20; i++) begin
      str_valid = 1; str_byte = 8'(i);
      cycle();
    end
    str_valid = 0;
    check8("R8 no result from unopened stream", str_code, 8'h00);

    // R1/R2/R3 with hand-computed constants
    tag = "R1";
    send_par('0, 0);
    check8("R1 all-zero descriptor", par_code, 8'hFE);
    tag = "R2";
    send_par(128'h0000_AB00, 0);
    check8("R2 code byte ignored", par_code, 8'hFE);
    tag = "R3";
    send_par(128'h0000_0001, 0);
    check8("R3 ownership bit ignored", par_code, 8'hFE);
    send_par(128'h0000_0081, 0);
    check8("R3 upper flag bits count", par_code, 8'h7E);
    tag = "R1";
    d = {16{8'h10}};
    send_par(d, 0);
    check8("R1 fifteen bytes of 0x10", par_code, 8'h0E);

    // R4/R5 parallel check mode
    tag = "R5";
    d = rnd_desc(); d[15:8] = ref_code(d);
    send_par(d, 1);
    check1("R5 matching code no error", par_err, 1'b0);
    d[15:8] = d[15:8] ^ 8'h04;
    send_par(d, 1);
    check1("R5 corrupted code flags error", par_err, 1'b1);
    tag = "R4";
    send_par(d, 0);
    check1("R4 generate mode quiet", par_err, 1'b0);

    // R6: back-to-back random words
    tag = "R6";
    for (int k = 0; k < 40; k++) begin
      par_valid = 1; par_word = rnd_desc(); par_check = k[0];
      if (k[1]) par_word[15:8] = ref_code(par_word);
      cycle();
    end
    par_valid = 0;
    cycle();

    // R7: stream, contiguous and with gaps (R11)
    tag = "R7";
    d = rnd_desc();
    send_str(d, 0, 0);
    check8("R7 stream code", str_code, ref_code(d));
    tag = "R11";
    send_str(d, 0, 3);
    check8("R11 gaps leave result unchanged", str_code, ref_code(d));

    // R5 stream check mode
    tag = "R5";
    d = rnd_desc(); d[15:8] = ref_code(d);
    send_str(d, 1, 1);
    d[15:8] = ~d[15:8];
    send_str(d, 1, 0);

    // R8: extra bytes after the sixteenth
    tag = "R8";
    for (int i = 0; i < 10; i++) begin
      str_valid = 1; str_byte = 8'hC3;
      cycle();
    end
    str_valid = 0;
    check8("R8 trailing bytes ignored", str_code, ref_code(d));

    // R9: restart mid-descriptor
    tag = "R9";
    for (int i = 0; i < 7; i++) begin
      str_start = (i == 0); str_valid = 1; str_byte = 8'hFF;
      cycle();
      str_start = 0;
    end
    str_valid = 0;
    d = rnd_desc();
    send_str(d, 0, 0);
    check8("R9 restart discards partial sum", str_code, ref_code(d));

    // mixed traffic on both paths
    tag = "R6";
    for (int k = 0; k < 300; k++) begin
      str_start = ($urandom % 23) == 0; str_check = $urandom;
      str_valid = $urandom; str_byte = $urandom;
      par_valid = $urandom; par_check = $urandom; par_word = rnd_desc();
      cycle();
    end
    str_start = 0; str_valid = 0; par_valid = 0;
    repeat (3) cycle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule